// File: doc/BRIEF.md
# Interrupt Controller Programming Interface

This block is the byte-wide configuration and status front end of an eight-input programmable interrupt controller. Software reaches it through two byte ports chosen by a single address bit (`a0`). A write to port 0 that has bit 4 set begins an initialization run. The run is then completed by one to three further port-1 writes, which set the vector base, the cascade byte and the mode byte. After that, port-1 writes load the interrupt mask, and port-0 writes are decoded as operation commands.

A command whose bits 4:3 are 00 is the end-of-interrupt and priority command. It is not executed here. It is handed to the priority core as a one-cycle strobe together with its byte. A command whose bits 4:3 are 01 selects which register a port-0 read returns. Port-0 reads return either the request vector or the in-service vector. Both vectors come in from the priority core. Port-1 reads return the mask. Read data is registered.

The initialization sequencer has five named states:
- `ST_ICW1`: waiting for the first init word. This is the state after reset.
- `ST_ICW2`: waiting for the vector base.
- `ST_ICW3`: waiting for the cascade byte.
- `ST_ICW4`: waiting for the mode byte.
- `ST_READY`: operating.

Its transitions are:
- `T_START`: from any state to `ST_ICW2`, on a port-0 write with bit 4 set.
- `T_BASE`: from `ST_ICW2` to `ST_ICW3`, `ST_ICW4` or `ST_READY`.
- `T_CASC`: from `ST_ICW3` to `ST_ICW4` or `ST_READY`.
- `T_MODE`: from `ST_ICW4` to `ST_READY`.

Top module: `irqc_prog_if`

## Requirements
- R1: After reset the block is waiting for the first init word (`ready`=0). `init_word`, `vec_base`, `cascade_word`, `mode_word`, `mask`, `cmd_byte` and `rdata` are all 0, and both strobes are low. The read-select field is 2'b10, so a port-0 read returns `req_vec`.
- R2: A port-0 write with bit 4 = 1 is accepted in every state. It stores the byte in `init_word` and makes the next port-1 write a vector-base write (`T_START`). It does not change `mask`, `vec_base`, `cascade_word` or `mode_word`.
- R3: While waiting for the vector base, a port-1 write stores the byte in `vec_base`. The next step is chosen from `init_word`:
  - cascade, when bit 1 = 0;
  - mode, when bit 1 = 1 and bit 0 = 1;
  - ready, when bit 1 = 1 and bit 0 = 0.
- R4: While waiting for the cascade byte, a port-1 write stores the byte in `cascade_word`. The next step is mode if `init_word` bit 0 = 1, and ready otherwise.
- R5: While waiting for the mode byte, a port-1 write stores the byte in `mode_word`, and `ready` rises.
- R6: When ready, a port-1 write loads `mask`. A port-1 write while waiting for the first init word changes no output.
- R7: When ready, a port-0 write with bits 4:3 = 00 raises `cmd_valid` for exactly one cycle after the write, with the written byte on `cmd_byte`. `cmd_byte` holds that value until the next such command.
- R8: When ready, a port-0 write with bits 4:3 = 01 stores bits 1:0 as the read-select field. It raises no strobe.
- R9: A port-0 write with bit 4 = 0 while not ready raises `bad_cmd` for one cycle and changes no other output. `bad_cmd` and `cmd_valid` are never high together.
- R10: A port-0 read puts `isr_vec` on `rdata` in the cycle after `rd_en` when the read-select field is 2'b11. For the values 00, 01 and 10 it puts `req_vec` there. `rdata` holds when no read is made.
- R11: A port-1 read puts `mask` on `rdata` in the cycle after `rd_en`.
- R12: `ready` is high exactly when the sequencer is in `ST_READY`. It rises in the cycle after the last init write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | One-cycle write request |
| rd_en | input | 1 | One-cycle read request |
| a0 | input | 1 | Port select: 0 = command port, 1 = data port |
| wdata | input | 8 | Write byte |
| req_vec | input | 8 | Request vector from the priority core |
| isr_vec | input | 8 | In-service vector from the priority core |
| rdata | output | 8 | Registered read data |
| ready | output | 1 | Initialization complete |
| init_word | output | 8 | Stored first init word |
| vec_base | output | 8 | Stored vector base |
| cascade_word | output | 8 | Stored cascade byte |
| mode_word | output | 8 | Stored mode byte |
| mask | output | 8 | Interrupt mask |
| cmd_valid | output | 1 | One-cycle strobe for an end-of-interrupt or priority command |
| cmd_byte | output | 8 | Byte of the last such command |
| bad_cmd | output | 1 | One-cycle strobe for a command that arrived before ready |

## Verification
The assertions assume that `wr_en`, `a0` and `wdata` are known and stable across each rising edge after reset. They also assume that a write lasts exactly the one cycle it is sampled. The stimulus drives every input on the falling edge and holds it through one rising edge. It never overlaps a read with a write, and it sets bit 4 of a port-0 byte only rarely, so that the sequencer spends most of its time ready. Randomized request and in-service vectors change only between operations, so each read sees one stable value.

// File: rtl/irqc_pkg.sv
package irqc_pkg;
    localparam int DATA_W    = 8;
    localparam int START_BIT = 4;   // port-0 byte: init-start flag
    localparam int CMD_HI    = 4;   // port-0 byte: command class field
    localparam int CMD_LO    = 3;
    localparam int SINGLE_B  = 1;   // init word: no cascade step
    localparam int MODE_B    = 0;   // init word: mode byte follows
    localparam int SEL_W     = 2;   // read-select field width
    localparam logic [SEL_W-1:0] SEL_RESET = 2'b10;
    localparam logic [SEL_W-1:0] SEL_ISR   = 2'b11;

    typedef enum logic [2:0] {
        ST_ICW1  = 3'd0,
        ST_ICW2  = 3'd1,
        ST_ICW3  = 3'd2,
        ST_ICW4  = 3'd3,
        ST_READY = 3'd4
    } step_t;
endpackage

// File: rtl/irqc_port0_decode.sv
module irqc_port0_decode
    import irqc_pkg::*;
(
    input  logic       wr_en,
    input  logic       a0,
    input  logic       start_bit,
    input  logic [1:0] cmd_field,
    input  logic       ready,
    output logic       hit_start,
    output logic       hit_cmd,
    output logic       hit_sel,
    output logic       hit_bad
);
    always_comb begin
        hit_start = 1'b0;
        hit_cmd   = 1'b0;
        hit_sel   = 1'b0;
        hit_bad   = 1'b0;
        if (wr_en && !a0) begin
            if (start_bit) begin
                hit_start = 1'b1;
            end else if (!ready) begin
                hit_bad = 1'b1;
            end else begin
                unique case (cmd_field)
                    2'b00:   hit_cmd = 1'b1;
                    2'b01:   hit_sel = 1'b1;
                    default: hit_bad = 1'b1;
                endcase
            end
        end
    end
endmodule

// File: rtl/irqc_init_seq.sv
module irqc_init_seq
    import irqc_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  logic  start,
    input  logic  p1_wr,
    input  logic  single,
    input  logic  need_mode,
    output step_t step,
    output logic  ready,
    output logic  ld_base,
    output logic  ld_casc,
    output logic  ld_mode,
    output logic  ld_mask
);
    step_t step_q, step_d;

    // next step
    always_comb begin
        step_d = step_q;
        if (start) begin
            step_d = ST_ICW2;                       // T_START
        end else if (p1_wr) begin
            unique case (step_q)
                ST_ICW1:  step_d = ST_ICW1;
                ST_ICW2: begin                      // T_BASE
                    if (!single)        step_d = ST_ICW3;
                    else if (need_mode) step_d = ST_ICW4;
                    else                step_d = ST_READY;
                end
                ST_ICW3:  step_d = need_mode ? ST_ICW4 : ST_READY; // T_CASC
                ST_ICW4:  step_d = ST_READY;        // T_MODE
                ST_READY: step_d = ST_READY;
                default:  step_d = ST_ICW1;
            endcase
        end
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) step_q <= ST_ICW1;
        else        step_q <= step_d;
    end

    // outputs
    always_comb begin
        ld_base = 1'b0;
        ld_casc = 1'b0;
        ld_mode = 1'b0;
        ld_mask = 1'b0;
        ready   = 1'b0;
        unique case (step_q)
            ST_ICW1:  ;
            ST_ICW2:  ld_base = p1_wr;
            ST_ICW3:  ld_casc = p1_wr;
            ST_ICW4:  ld_mode = p1_wr;
            ST_READY: begin
                ready   = 1'b1;
                ld_mask = p1_wr;
            end
            default:  ;
        endcase
    end

    assign step = step_q;
endmodule

// File: rtl/irqc_read_mux.sv
module irqc_read_mux
    import irqc_pkg::*;
#(
    parameter int DW = DATA_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             rd_en,
    input  logic             a0,
    input  logic [SEL_W-1:0] sel,
    input  logic [DW-1:0]    req_vec,
    input  logic [DW-1:0]    isr_vec,
    input  logic [DW-1:0]    mask,
    output logic [DW-1:0]    rdata
);
    logic [DW-1:0] pick;

    always_comb begin
        if (a0)                pick = mask;
        else if (sel == SEL_ISR) pick = isr_vec;
        else                   pick = req_vec;
    end

    always_ff @(posedge clk) begin
        if (!rst_n)     rdata <= '0;
        else if (rd_en) rdata <= pick;
    end
endmodule

// File: rtl/irqc_prog_if.sv
module irqc_prog_if
    import irqc_pkg::*;
#(
    parameter int DW = DATA_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic          rd_en,
    input  logic          a0,
    input  logic [DW-1:0] wdata,
    input  logic [DW-1:0] req_vec,
    input  logic [DW-1:0] isr_vec,
    output logic [DW-1:0] rdata,
    output logic          ready,
    output logic [DW-1:0] init_word,
    output logic [DW-1:0] vec_base,
    output logic [DW-1:0] cascade_word,
    output logic [DW-1:0] mode_word,
    output logic [DW-1:0] mask,
    output logic          cmd_valid,
    output logic [DW-1:0] cmd_byte,
    output logic          bad_cmd
);
    step_t            step_q;
    logic             hit_start, hit_cmd, hit_sel, hit_bad;
    logic             ld_base, ld_casc, ld_mode, ld_mask;
    logic             p1_wr;
    logic [SEL_W-1:0] sel_q;

    assign p1_wr = wr_en && a0;

    irqc_port0_decode u_dec (
        .wr_en     (wr_en),
        .a0        (a0),
        .start_bit (wdata[START_BIT]),
        .cmd_field (wdata[CMD_HI:CMD_LO]),
        .ready     (ready),
        .hit_start (hit_start),
        .hit_cmd   (hit_cmd),
        .hit_sel   (hit_sel),
        .hit_bad   (hit_bad)
    );

    irqc_init_seq u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (hit_start),
        .p1_wr     (p1_wr),
        .single    (init_word[SINGLE_B]),
        .need_mode (init_word[MODE_B]),
        .step      (step_q),
        .ready     (ready),
        .ld_base   (ld_base),
        .ld_casc   (ld_casc),
        .ld_mode   (ld_mode),
        .ld_mask   (ld_mask)
    );

    // configuration registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            init_word    <= '0;
            vec_base     <= '0;
            cascade_word <= '0;
            mode_word    <= '0;
            mask         <= '0;
            sel_q        <= SEL_RESET;
        end else begin
            if (hit_start) init_word    <= wdata;
            if (ld_base)   vec_base     <= wdata;
            if (ld_casc)   cascade_word <= wdata;
            if (ld_mode)   mode_word    <= wdata;
            if (ld_mask)   mask         <= wdata;
            if (hit_sel)   sel_q        <= wdata[SEL_W-1:0];
        end
    end

    // command strobes to the priority core
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cmd_valid <= 1'b0;
            cmd_byte  <= '0;
            bad_cmd   <= 1'b0;
        end else begin
            cmd_valid <= hit_cmd;
            bad_cmd   <= hit_bad;
            if (hit_cmd) cmd_byte <= wdata;
        end
    end

    irqc_read_mux #(.DW(DW)) u_rd (
        .clk     (clk),
        .rst_n   (rst_n),
        .rd_en   (rd_en),
        .a0      (a0),
        .sel     (sel_q),
        .req_vec (req_vec),
        .isr_vec (isr_vec),
        .mask    (mask),
        .rdata   (rdata)
    );
endmodule

// File: rtl/irqc_prog_if_chk.sv
module irqc_prog_if_chk
    import irqc_pkg::*;
(
    input logic        clk,
    input logic        rst_n,
    input logic        wr_en,
    input logic        a0,
    input logic [7:0]  wdata,
    input logic        ready,
    input logic [7:0]  mask,
    input logic        cmd_valid,
    input logic [7:0]  cmd_byte,
    input logic        bad_cmd,
    input step_t       step_q
);
    a_r2_start_restarts: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !a0 && wdata[START_BIT]) |=> (step_q == ST_ICW2 && !ready));

    a_r3_base_advances: assert property (@(posedge clk) disable iff (!rst_n)
        (step_q == ST_ICW2 && wr_en && a0) |=> (step_q != ST_ICW2 && step_q != ST_ICW1));

    a_r5_mode_finishes: assert property (@(posedge clk) disable iff (!rst_n)
        (step_q == ST_ICW4 && wr_en && a0) |=> ready);

    a_r6_mask_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_en && a0 && ready) |=> $stable(mask));

    a_r7_cmd_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        (ready && wr_en && !a0 && wdata[CMD_HI:CMD_LO] == 2'b00)
            |=> (cmd_valid && cmd_byte == $past(wdata)));

    a_r7_cmd_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !(ready && wr_en && !a0 && wdata[CMD_HI:CMD_LO] == 2'b00) |=> !cmd_valid);

    a_r9_bad_flag: assert property (@(posedge clk) disable iff (!rst_n)
        (!ready && wr_en && !a0 && !wdata[START_BIT]) |=> (bad_cmd && $stable(mask)));

    a_r9_strobes_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({cmd_valid, bad_cmd}));
endmodule

bind irqc_prog_if irqc_prog_if_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en     (wr_en),
    .a0        (a0),
    .wdata     (wdata),
    .ready     (ready),
    .mask      (mask),
    .cmd_valid (cmd_valid),
    .cmd_byte  (cmd_byte),
    .bad_cmd   (bad_cmd),
    .step_q    (step_q)
);

// File: tb/irqc_prog_if_test.sv
`timescale 1ns/1ps
module irqc_prog_if_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0, rd_en = 1'b0, a0 = 1'b0;
    logic [7:0] wdata = '0, req_vec = '0, isr_vec = '0;
    logic [7:0] rdata, init_word, vec_base, cascade_word, mode_word, mask, cmd_byte;
    logic       ready, cmd_valid, bad_cmd;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    // model: 0 first word, 1 base, 2 cascade, 3 mode, 4 ready
    int         m_step;
    logic [7:0] m_init, m_base, m_casc, m_mode, m_mask, m_cbyte, m_rdata;
    logic [1:0] m_sel;
    logic       e_cmd, e_bad;

    always #2 clk = ~clk;

    irqc_prog_if uut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .a0(a0),
        .wdata(wdata), .req_vec(req_vec), .isr_vec(isr_vec), .rdata(rdata),
        .ready(ready), .init_word(init_word), .vec_base(vec_base),
        .cascade_word(cascade_word), .mode_word(mode_word), .mask(mask),
        .cmd_valid(cmd_valid), .cmd_byte(cmd_byte), .bad_cmd(bad_cmd)
    );

    task automatic chk(string tag, logic [7:0] act, logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %02h expected %02h", tag, act, exp);
        end
    endtask

    function automatic int step_after_data(int s, logic [7:0] iw);
        case (s)
            1:       return !iw[1] ? 2 : (iw[0] ? 3 : 4);
            2:       return iw[0] ? 3 : 4;
            3:       return 4;
            default: return s;
        endcase
    endfunction

    function automatic logic [7:0] read_pick(logic port, logic [1:0] s,
                                             logic [7:0] rq, logic [7:0] is,
                                             logic [7:0] mk);
        if (port)        return mk;
        if (s == 2'b11)  return is;
        return rq;
    endfunction

    task automatic compare_all();
        chk("R12 ready",        {7'd0, ready},     {7'd0, (m_step == 4)});
        chk("R2 init_word",     init_word,         m_init);
        chk("R3 vec_base",      vec_base,          m_base);
        chk("R4 cascade_word",  cascade_word,      m_casc);
        chk("R5 mode_word",     mode_word,         m_mode);
        chk("R6 mask",          mask,              m_mask);
        chk("R7 cmd_valid",     {7'd0, cmd_valid}, {7'd0, e_cmd});
        chk("R7 cmd_byte",      cmd_byte,          m_cbyte);
        chk("R9 bad_cmd",       {7'd0, bad_cmd},   {7'd0, e_bad});
        chk("R10 R11 rdata",    rdata,             m_rdata);
    endtask

    task automatic do_write(logic port, logic [7:0] d);
        e_cmd = 1'b0;
        e_bad = 1'b0;
        wr_en = 1'b1; a0 = port; wdata = d;
        @(negedge clk);
        wr_en = 1'b0;
        if (!port) begin
            if (d[4]) begin
                m_init = d; m_step = 1;
            end else if (m_step != 4) begin
                e_bad = 1'b1;
            end else if (!d[3]) begin
                e_cmd = 1'b1; m_cbyte = d;
            end else begin
                m_sel = d[1:0];
            end
        end else begin
            case (m_step)
                1: m_base = d;
                2: m_casc = d;
                3: m_mode = d;
                4: m_mask = d;
                default: ;
            endcase
            m_step = step_after_data(m_step, m_init);
        end
        compare_all();
    endtask

    task automatic do_read(logic port);
        e_cmd = 1'b0; e_bad = 1'b0;
        rd_en = 1'b1; a0 = port;
        m_rdata = read_pick(port, m_sel, req_vec, isr_vec, m_mask);
        @(negedge clk);
        rd_en = 1'b0;
        compare_all();
    endtask

    task automatic do_idle();
        e_cmd = 1'b0; e_bad = 1'b0;
        @(negedge clk);
        compare_all();
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        void'($urandom(32'd4242));
        m_step = 0; m_init = 0; m_base = 0; m_casc = 0; m_mode = 0;
        m_mask = 0; m_cbyte = 0; m_rdata = 0; m_sel = 2'b10;
        e_cmd = 0; e_bad = 0;
        req_vec = 8'h5A; isr_vec = 8'hC3;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state
        compare_all();
        do_read(1'b0);                 // R1 / R10: default select returns requests
        // R6: data write before any init word ignored; R9: command before ready
        do_write(1'b1, 8'hA5);
        do_write(1'b0, 8'h20);
        // R3/R4/R5: full run with cascade and mode steps
        do_write(1'b0, 8'h11);
        do_write(1'b1, 8'h20);
        do_write(1'b1, 8'h04);
        do_write(1'b1, 8'h01);
        do_write(1'b1, 8'hF0);         // R6: mask loaded
        do_read(1'b1);                 // R11
        do_write(1'b0, 8'h0B);         // R8: select in-service
        do_read(1'b0);                 // R10
        do_write(1'b0, 8'h09);         // R8: low bits 01 -> requests
        do_read(1'b0);
        do_write(1'b0, 8'h08);         // low bits 00 -> requests
        do_read(1'b0);
        do_write(1'b0, 8'h20);         // R7
        do_write(1'b0, 8'h63);         // R7 back to back
        do_idle();                     // R7: strobe drops
        // R3 other branches: single+mode, single only, cascade without mode
        do_write(1'b0, 8'h13);  do_write(1'b1, 8'h40);  do_write(1'b1, 8'h1D);
        do_write(1'b0, 8'h12);  do_write(1'b1, 8'h48);
        do_write(1'b0, 8'h10);  do_write(1'b1, 8'h70);  do_write(1'b1, 8'h02);
        do_write(1'b0, 8'h17);         // R2: restart from ready keeps mask
        // random mix
        for (int i = 0; i < 3000; i++) begin
            int kind;
            logic [7:0] d;
            req_vec = 8'($urandom);
            isr_vec = 8'($urandom);
            kind = int'($urandom_range(0, 9));
            d = 8'($urandom);
            if (kind <= 3) begin
                if ($urandom_range(0, 9) != 0) d[4] = 1'b0;
                do_write(1'b0, d);
            end else if (kind <= 6) begin
                do_write(1'b1, d);
            end else if (kind <= 8) begin
                do_read(kind[0]);
            end else begin
                do_idle();
            end
        end
        finish_run();
    end
endmodule